// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the hardware half of a receive DMA path. A MAC receive path hands it one byte per cycle, with markers on the first and the last byte of each frame and with address-filter verdicts on the first byte. The block spreads each frame over a chain of fixed 128-byte buffers. Each buffer is described by a two-word descriptor in a small local descriptor memory: an address word, then a status word. After filling a buffer it writes the status word. One cycle later it sets the ownership bit in the address word, which hands the buffer to software.

Software prepares the ring through a host port. It writes each address word with a 128-byte-aligned buffer base and the flags in bits 1:0 cleared, except that the last descriptor of the ring carries the wrap flag. Software then polls for the ownership bit, reads the status word and the buffer bytes, and gives the descriptor back by clearing bit 0. If the engine needs a buffer that software still holds, it drops the rest of the frame and raises a sticky no-buffer flag.

Top module: `rxring_writer`

## Requirements
- R1: After reset rx_busy, rx_done and rx_nobuf are 0, and the first buffer used is descriptor 0.
- R2: Byte k of a frame goes to buffer memory byte base + (k mod 128) of the (k div 128)-th descriptor used by the frame, where base is the address word with bits 6:0 cleared. A frame of N bytes uses ceil(N/128) consecutive descriptors.
- R3: Status bit 14 is 1 only in the first descriptor of a frame, and status bit 15 is 1 only in the descriptor holding the last byte.
- R4: Status bits 11:0 hold the total frame length in bytes in the last descriptor and are 0 in the others.
- R5: Status bit 31 is the broadcast flag, bits 26, 25, 24 and 23 are address-match flags 1, 2, 3 and 4 (in_sa_hit bits 0 to 3), and bit 22 is the type match. All are taken with the start-of-frame byte and written into every descriptor of the frame.
- R6: A filled descriptor's address word equals its old value with bit 0 set; bits 31:1 are unchanged.
- R7: The status word of a descriptor is written one cycle before its ownership bit is set, so status is final whenever bit 0 reads 1.
- R8: After a descriptor whose address-word bit 1 is 1, the next descriptor used is descriptor 0. With the default options the physical last descriptor also wraps.
- R9: When a buffer is needed and the current descriptor has bit 0 set, the rest of the frame is dropped and that descriptor is not written. rx_nobuf becomes 1 and stays 1 until reset, and the engine resumes at the same descriptor with the next frame once software releases it.
- R10: rx_done pulses for one cycle per completed frame, in the cycle the last descriptor's ownership bit is being set. A dropped frame gives no pulse.
- R11: rx_busy is 1 while a frame is in progress, including a frame being dropped, or while a descriptor writeback is pending.
- R12: Bytes that arrive outside a frame (no start-of-frame marker since the last end marker) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte valid |
| in_data | input | 8 | Received byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_bcast | input | 1 | Broadcast destination, taken with the first byte |
| in_sa_hit | input | 4 | Specific-address matches 1..4 (bit 0 = match 1) |
| in_type_hit | input | 1 | Type-ID match |
| host_we | input | 1 | Host write to a descriptor word |
| host_waddr | input | log2(2*NDESC) | Descriptor word index (even = address word, odd = status word) |
| host_wdata | input | 32 | Host write data |
| host_rsel | input | 1 | Read select: 0 descriptor word, 1 buffer byte |
| host_raddr | input | BUF_AW | Read index (descriptor word index or buffer byte address) |
| host_rdata | output | 32 | Read data (a byte read is zero-extended) |
| rx_done | output | 1 | One-cycle pulse when a frame has been handed over |
| rx_busy | output | 1 | Frame in progress or writeback pending |
| rx_nobuf | output | 1 | Sticky: a frame was dropped for lack of a free buffer |

## Verification
A wrong descriptor pointer shows as soon as the next buffer is handed over: the ownership bit appears on a descriptor other than the one expected, and the wrong buffer holds the bytes. A wrong offset or length counter corrupts the byte image or the length field of the same buffer. A fault in the first-buffer or flag registers shows in status bits 14, 31 and 26:22 of the next descriptor written. A writeback pipeline that sets ownership before status lets the polling host read a stale status word in the very cycle bit 0 rises. A broken ownership check shows only when the ring is full: the next frame either overwrites a held buffer or fails to raise rx_nobuf and still pulses rx_done.

// File: rtl/rxring_pkg.sv
package rxring_pkg;

   localparam int BUF_BYTES = 128;
   localparam int OFF_W     = 7;
   localparam int LEN_W     = 12;
   localparam int ST_FIRST  = 14;
   localparam int ST_LAST   = 15;
   localparam int ST_BCAST  = 31;
   localparam int ST_SA1    = 26;
   localparam int ST_TYPE   = 22;

   typedef struct packed {
      logic       bcast;
      logic [3:0] sa;
      logic       type_hit;
   } rxr_flags_t;

   function automatic logic [31:0] mk_status(input logic first, input logic last,
                                             input logic [LEN_W-1:0] len,
                                             input rxr_flags_t f);
      logic [31:0] s;
      s = '0;
      s[LEN_W-1:0] = len;
      s[ST_FIRST]  = first;
      s[ST_LAST]   = last;
      s[ST_BCAST]  = f.bcast;
      s[ST_TYPE]   = f.type_hit;
      for (int i = 0; i < 4; i++) s[ST_SA1-i] = f.sa[i];
      return s;
   endfunction

endpackage

// File: rtl/rxring_desc_mem.sv
module rxring_desc_mem #(
   parameter int NDESC = 8,
   localparam int IDX_W = $clog2(NDESC),
   localparam int DWW   = IDX_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_we,
   input  logic [DWW-1:0]   host_waddr,
   input  logic [31:0]      host_wdata,
   input  logic [DWW-1:0]   host_raddr,
   output logic [31:0]      host_word,
   input  logic             st_we,
   input  logic [IDX_W-1:0] st_idx,
   input  logic [31:0]      st_data,
   input  logic             own_we,
   input  logic [IDX_W-1:0] own_idx,
   input  logic [IDX_W-1:0] cur_idx,
   output logic [31:0]      cur_addr
);
   logic [NDESC-1:0][31:0] addr_all;
   logic [NDESC-1:0][31:0] stat_all;

   for (genvar g = 0; g < NDESC; g++) begin : g_desc
      localparam logic [DWW-1:0]   AW_IDX = DWW'(2 * g);
      localparam logic [DWW-1:0]   SW_IDX = DWW'(2 * g + 1);
      localparam logic [IDX_W-1:0] D_IDX  = IDX_W'(g);
      logic [31:0] a_q, s_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            a_q <= '0;
            s_q <= '0;
         end else begin
            if (host_we && host_waddr == AW_IDX) a_q <= host_wdata;
            if (own_we && own_idx == D_IDX)      a_q <= a_q | 32'd1;
            if (host_we && host_waddr == SW_IDX) s_q <= host_wdata;
            if (st_we && st_idx == D_IDX)        s_q <= st_data;
         end
      end
      assign addr_all[g] = a_q;
      assign stat_all[g] = s_q;
   end

   assign cur_addr  = addr_all[cur_idx];
   assign host_word = host_raddr[0] ? stat_all[host_raddr[DWW-1:1]]
                                    : addr_all[host_raddr[DWW-1:1]];
endmodule

// File: rtl/rxring_buf_mem.sv
module rxring_buf_mem #(
   parameter int BUF_AW = 10
) (
   input  logic              clk,
   input  logic              we,
   input  logic [BUF_AW-1:0] waddr,
   input  logic [7:0]        wdata,
   input  logic [BUF_AW-1:0] raddr,
   output logic [7:0]        rdata
);
   logic [7:0] mem [2**BUF_AW];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end
   assign rdata = mem[raddr];
endmodule

// File: rtl/rxring_wb.sv
module rxring_wb #(
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             close_v,
   input  logic [IDX_W-1:0] close_idx,
   input  logic [31:0]      close_status,
   input  logic             close_last,
   output logic             st_we,
   output logic [IDX_W-1:0] st_idx,
   output logic [31:0]      st_data,
   output logic             own_we,
   output logic [IDX_W-1:0] own_idx,
   output logic             done,
   output logic             pending
);
   logic s1_last, s2_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_we   <= 1'b0;
         st_idx  <= '0;
         st_data <= '0;
         s1_last <= 1'b0;
         own_we  <= 1'b0;
         own_idx <= '0;
         s2_last <= 1'b0;
      end else begin
         st_we   <= close_v;
         st_idx  <= close_idx;
         st_data <= close_status;
         s1_last <= close_v & close_last;
         own_we  <= st_we;
         own_idx <= st_idx;
         s2_last <= s1_last;
      end
   end

   assign done    = own_we & s2_last;
   assign pending = st_we | own_we;
endmodule

// File: rtl/rxring_writer.sv
module rxring_writer
   import rxring_pkg::*;
#(
   parameter int NDESC       = 8,
   parameter int BUF_AW      = 10,
   parameter bit WRAP_AT_END = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         in_valid,
   input  logic [7:0]                   in_data,
   input  logic                         in_sof,
   input  logic                         in_eof,
   input  logic                         in_bcast,
   input  logic [3:0]                   in_sa_hit,
   input  logic                         in_type_hit,
   input  logic                         host_we,
   input  logic [$clog2(2*NDESC)-1:0]   host_waddr,
   input  logic [31:0]                  host_wdata,
   input  logic                         host_rsel,
   input  logic [BUF_AW-1:0]            host_raddr,
   output logic [31:0]                  host_rdata,
   output logic                         rx_done,
   output logic                         rx_busy,
   output logic                         rx_nobuf
);
   localparam int IDX_W = $clog2(NDESC);
   localparam int DWW   = IDX_W + 1;

   if (NDESC < 4 || (NDESC & (NDESC - 1)) != 0) begin : g_bad_ndesc
      $error("NDESC must be a power of two and at least 4");
   end
   if (BUF_AW < 8 || BUF_AW > 24 || BUF_AW < DWW) begin : g_bad_bufaw
      $error("BUF_AW out of range");
   end

   logic [IDX_W-1:0] cur_idx;
   logic [OFF_W-1:0] off;
   logic [LEN_W-1:0] flen;
   logic             in_frame, dropping, first_buf, nobuf_q;
   rxr_flags_t       flags_q, in_fl, eff_flags;

   logic [31:0]      cur_addr;
   logic             owned, wrap_here;
   logic             active, blocked, take, buf_close, eff_first;
   logic [OFF_W-1:0] eff_off;
   logic [LEN_W-1:0] len_now;
   logic [IDX_W-1:0] nxt_idx;
   logic [31:0]      status_now;

   logic             st_we, own_we, wb_pending;
   logic [IDX_W-1:0] st_idx, own_idx;
   logic [31:0]      st_data, desc_word;
   logic [7:0]       buf_byte;
   logic             unused_addr_bits;

   assign in_fl     = '{bcast: in_bcast, sa: in_sa_hit, type_hit: in_type_hit};
   assign owned     = cur_addr[0];

   if (WRAP_AT_END) begin : g_endwrap
      assign wrap_here = cur_addr[1] | (cur_idx == IDX_W'(NDESC - 1));
   end else begin : g_flagwrap
      assign wrap_here = cur_addr[1];
   end

   assign active     = in_valid & (in_sof | (in_frame & ~dropping));
   assign eff_off    = in_sof ? '0 : off;
   assign blocked    = active & (eff_off == '0) & owned;
   assign take       = active & ~blocked;
   assign buf_close  = take & (in_eof | (eff_off == OFF_W'(BUF_BYTES - 1)));
   assign eff_first  = in_sof | first_buf;
   assign eff_flags  = in_sof ? in_fl : flags_q;
   assign len_now    = (in_sof ? '0 : flen) + LEN_W'(1);
   assign nxt_idx    = wrap_here ? '0 : cur_idx + IDX_W'(1);
   assign status_now = mk_status(eff_first, in_eof, in_eof ? len_now : '0, eff_flags);
   assign unused_addr_bits = ^{cur_addr[31:BUF_AW], cur_addr[OFF_W-1:2]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_idx   <= '0;
         off       <= '0;
         flen      <= '0;
         in_frame  <= 1'b0;
         dropping  <= 1'b0;
         first_buf <= 1'b0;
         nobuf_q   <= 1'b0;
         flags_q   <= '0;
      end else begin
         if (active) off <= take ? (buf_close ? '0 : eff_off + OFF_W'(1)) : '0;
         if (take) begin
            flen      <= len_now;
            first_buf <= buf_close ? 1'b0 : eff_first;
         end
         if (buf_close) cur_idx <= nxt_idx;
         if (in_valid && in_sof) begin
            flags_q  <= in_fl;
            in_frame <= ~in_eof;
            dropping <= blocked & ~in_eof;
         end else if (in_valid && in_frame) begin
            if (in_eof) begin
               in_frame <= 1'b0;
               dropping <= 1'b0;
            end else if (blocked) begin
               dropping <= 1'b1;
            end
         end
         if (blocked) nobuf_q <= 1'b1;
      end
   end

   rxring_desc_mem #(.NDESC(NDESC)) u_desc (
      .clk(clk), .rst_n(rst_n),
      .host_we(host_we), .host_waddr(host_waddr), .host_wdata(host_wdata),
      .host_raddr(host_raddr[DWW-1:0]), .host_word(desc_word),
      .st_we(st_we), .st_idx(st_idx), .st_data(st_data),
      .own_we(own_we), .own_idx(own_idx),
      .cur_idx(cur_idx), .cur_addr(cur_addr)
   );

   rxring_buf_mem #(.BUF_AW(BUF_AW)) u_buf (
      .clk(clk), .we(take),
      .waddr({cur_addr[BUF_AW-1:OFF_W], eff_off}), .wdata(in_data),
      .raddr(host_raddr), .rdata(buf_byte)
   );

   rxring_wb #(.IDX_W(IDX_W)) u_wb (
      .clk(clk), .rst_n(rst_n),
      .close_v(buf_close), .close_idx(cur_idx), .close_status(status_now),
      .close_last(in_eof),
      .st_we(st_we), .st_idx(st_idx), .st_data(st_data),
      .own_we(own_we), .own_idx(own_idx),
      .done(rx_done), .pending(wb_pending)
   );

   assign host_rdata = host_rsel ? {24'd0, buf_byte} : desc_word;
   assign rx_busy    = in_frame | wb_pending;
   assign rx_nobuf   = nobuf_q;
endmodule

// File: rtl/rxring_chk.sv
module rxring_chk #(
   parameter int NDESC = 8,
   localparam int IDX_W = $clog2(NDESC)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             buf_close,
   input logic             wrap_here,
   input logic [IDX_W-1:0] cur_idx,
   input logic             st_we,
   input logic [IDX_W-1:0] st_idx,
   input logic             own_we,
   input logic [IDX_W-1:0] own_idx,
   input logic             rx_done,
   input logic             rx_busy,
   input logic             rx_nobuf
);
   // R7
   status_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      own_we |-> ($past(st_we) && $past(st_idx) == own_idx));

   // R8
   wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_close && wrap_here) |=> (cur_idx == '0));

   // R9
   nobuf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_nobuf |=> rx_nobuf);

   // R10
   done_with_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |-> own_we);

   // R11
   busy_on_writeback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_we || own_we) |-> rx_busy);
endmodule

bind rxring_writer rxring_chk #(.NDESC(NDESC)) u_chk (
   .clk(clk), .rst_n(rst_n), .buf_close(buf_close), .wrap_here(wrap_here),
   .cur_idx(cur_idx), .st_we(st_we), .st_idx(st_idx), .own_we(own_we),
   .own_idx(own_idx), .rx_done(rx_done), .rx_busy(rx_busy), .rx_nobuf(rx_nobuf)
);

// File: tb/tb_rxring_writer.sv
`timescale 1ns/1ps
module tb_rxring_writer;
   localparam int NDESC  = 8;
   localparam int BUF_AW = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 0, in_sof = 0, in_eof = 0, in_bcast = 0, in_type_hit = 0;
   logic [7:0] in_data = 0;
   logic [3:0] in_sa_hit = 0;
   logic host_we = 0, host_rsel = 0;
   logic [3:0] host_waddr = 0;
   logic [31:0] host_wdata = 0;
   logic [BUF_AW-1:0] host_raddr = 0;
   logic [31:0] host_rdata;
   logic rx_done, rx_busy, rx_nobuf;

   always #2.5 clk = ~clk;

   rxring_writer #(.NDESC(NDESC), .BUF_AW(BUF_AW)) dut (.*);

   typedef struct {
      int idx; logic [31:0] addr; logic [31:0] stat; int seed; int base; int n;
   } item_t;
   item_t q[$];

   int d_chk = 0, d_err = 0, m_chk = 0, m_err = 0;
   int done_cnt = 0, exp_done = 0;
   int rel_req = 0, rel_ack = 0;
   bit auto_rel = 1;
   bit wd_fail = 0;
   bit [NDESC-1:0] wrap_cfg = 8'h80;
   bit [NDESC-1:0] owned_m = '0;
   int exp_idx = 0;

   always @(posedge clk) if (rx_done) done_cnt <= done_cnt + 1;

   task automatic dchk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      d_chk++;
      if (!ok) begin d_err++; $display("FAIL %s act=%h exp=%h", req, act, exp); end
   endtask

   task automatic mchk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      m_chk++;
      if (!ok) begin m_err++; $display("FAIL %s act=%h exp=%h", req, act, exp); end
   endtask

   // Monitor: owns the host port; pops expected buffers as they are handed over.
   initial begin
      forever begin
         @(negedge clk); #1;
         if (rel_ack != rel_req) begin
            for (int i = 0; i < NDESC; i++) begin
               host_we = 1; host_waddr = 4'(2*i);
               host_wdata = (i*128) | (32'(wrap_cfg[i]) << 1);
               @(negedge clk); #1;
            end
            host_we = 0;
            rel_ack++;
         end else if (q.size() > 0) begin
            item_t it;
            logic [31:0] aw, st;
            int bad;
            it = q[0];
            host_rsel = 0; host_raddr = BUF_AW'(2*it.idx); #0.001;
            aw = host_rdata;
            if (aw[0]) begin
               host_raddr = BUF_AW'(2*it.idx + 1); #0.001;
               st = host_rdata;
               mchk(aw == it.addr, "R6 address word after fill", aw, it.addr);
               mchk(st[15:14] == it.stat[15:14], "R3 R7 first/last bits", st, it.stat);
               mchk(st[11:0] == it.stat[11:0], "R4 length field", st, it.stat);
               mchk((st & 32'h87C0_0000) == (it.stat & 32'h87C0_0000), "R5 filter flags", st, it.stat);
               bad = 0;
               host_rsel = 1;
               for (int j = 0; j < it.n; j++) begin
                  host_raddr = BUF_AW'(it.idx*128 + j); #0.001;
                  if (host_rdata[7:0] != 8'(it.seed + it.base + j)) bad++;
               end
               host_rsel = 0;
               mchk(bad == 0, "R2 buffer bytes (mismatch count)", bad, 0);
               void'(q.pop_front());
               if (auto_rel) begin
                  @(posedge clk); #0.1;
                  host_we = 1; host_waddr = 4'(2*it.idx); host_wdata = aw & ~32'd1;
                  @(posedge clk); #0.1;
                  host_we = 0;
               end
            end
         end
      end
   end

   task automatic release_all();
      rel_req++;
      wait (rel_ack == rel_req);
      owned_m = '0;
      repeat (2) @(negedge clk);
   endtask

   task automatic send_frame(input int n, input int seed, input logic bc,
                             input logic [3:0] sa, input logic ty, input int gap);
      int nb;
      bit dropped;
      nb = (n + 127) / 128;
      dropped = 0;
      for (int k = 0; k < nb; k++) begin
         item_t it;
         if (owned_m[exp_idx]) begin dropped = 1; break; end
         it.idx = exp_idx;
         it.addr = (exp_idx*128) | (32'(wrap_cfg[exp_idx]) << 1) | 32'd1;
         it.stat = '0;
         it.stat[14] = (k == 0);
         it.stat[15] = (k == nb-1);
         if (k == nb-1) it.stat[11:0] = 12'(n);
         it.stat[31] = bc;
         it.stat[26] = sa[0]; it.stat[25] = sa[1]; it.stat[24] = sa[2]; it.stat[23] = sa[3];
         it.stat[22] = ty;
         it.seed = seed; it.base = k*128;
         it.n = (k == nb-1) ? n - 128*k : 128;
         q.push_back(it);
         if (!auto_rel) owned_m[exp_idx] = 1;
         exp_idx = (wrap_cfg[exp_idx] || exp_idx == NDESC-1) ? 0 : exp_idx + 1;
      end
      if (!dropped) exp_done++;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (i == 1) dchk(rx_busy == 1'b1, "R11 busy during frame", rx_busy, 1);
         in_valid = 1; in_data = 8'(seed + i); in_sof = (i == 0); in_eof = (i == n-1);
         in_bcast = (i == 0) ? bc : 1'b0;
         in_sa_hit = (i == 0) ? sa : 4'h0;
         in_type_hit = (i == 0) ? ty : 1'b0;
      end
      @(negedge clk);
      in_valid = 0; in_sof = 0; in_eof = 0; in_bcast = 0; in_sa_hit = 0; in_type_hit = 0;
      repeat (gap) @(negedge clk);
   endtask

   task automatic wait_idle(input string req);
      for (int c = 0; c < 4000; c++) begin
         @(negedge clk);
         if (q.size() == 0 && !rx_busy) break;
      end
      repeat (4) @(negedge clk);
      dchk(q.size() == 0, req, q.size(), 0);
      dchk(done_cnt == exp_done, "R10 done pulse count", done_cnt, exp_done);
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", d_chk + m_chk, d_err + m_err + (wd_fail ? 1 : 0));
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      wd_fail = 1;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      dchk(rx_busy == 0, "R1 busy after reset", rx_busy, 0);
      dchk(rx_done == 0, "R1 done after reset", rx_done, 0);
      dchk(rx_nobuf == 0, "R1 nobuf after reset", rx_nobuf, 0);
      release_all();

      // R12: stray bytes without a start marker
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         in_valid = 1; in_data = 8'hEE; in_eof = (i == 4);
      end
      @(negedge clk); in_valid = 0; in_eof = 0;
      repeat (4) @(negedge clk);
      dchk(rx_busy == 0, "R12 stray bytes leave block idle", rx_busy, 0);
      dchk(done_cnt == 0, "R12 stray bytes give no done", done_cnt, 0);

      // R1 R2 R5: first frame lands in descriptor 0
      send_frame(60, 10, 1'b1, 4'h0, 1'b0, 2);
      wait_idle("R1 R2 first frame handed to descriptor 0");
      send_frame(128, 50, 1'b0, 4'b0001, 1'b0, 2);
      send_frame(300, 90, 1'b0, 4'b1000, 1'b1, 2);
      send_frame(200, 7, 1'b1, 4'b0110, 1'b0, 2);
      send_frame(250, 33, 1'b0, 4'h0, 1'b1, 2);
      wait_idle("R8 chain across wrap at last descriptor");

      // R8: wrap flag placed mid-ring
      wrap_cfg = 8'h08;
      release_all();
      send_frame(300, 120, 1'b0, 4'b0010, 1'b0, 2);
      send_frame(100, 200, 1'b1, 4'h0, 1'b0, 2);
      send_frame(1, 3, 1'b0, 4'b0100, 1'b0, 0);
      send_frame(2, 4, 1'b1, 4'h0, 1'b1, 0);
      wait_idle("R8 wrap flag on descriptor 3 returns to 0");

      // R9: ring full, mid-frame drop then drop at start
      auto_rel = 0;
      send_frame(600, 77, 1'b0, 4'h0, 1'b0, 2);
      send_frame(50, 5, 1'b1, 4'h0, 1'b0, 2);
      wait_idle("R9 buffers before the drop handed over");
      dchk(rx_nobuf == 1, "R9 nobuf raised on held descriptor", rx_nobuf, 1);
      dchk(rx_busy == 0, "R11 idle after dropped frames", rx_busy, 0);

      wrap_cfg = 8'h80;
      auto_rel = 1;
      release_all();
      send_frame(70, 150, 1'b0, 4'b1111, 1'b1, 2);
      wait_idle("R9 resume at held descriptor");
      dchk(rx_nobuf == 1, "R9 nobuf stays set", rx_nobuf, 1);
      send_frame(130, 9, 1'b1, 4'h0, 1'b0, 2);
      wait_idle("R2 two-buffer frame after resume");
      finish_run();
   end
endmodule